// File: doc/BRIEF.md
# Line Interface Loopback and All-Ones Steering

This block sits in each channel of a line interface, between the transmit and receive data paths. It chooses where data goes in four ways: straight through, an analog-style loop where the driver signal returns to the receive side, a digital loop where transmit data returns to the receive outputs by way of the encoder tap or the jitter attenuator, and a remote loop where recovered line data is sent back out to the line. It can also replace transmit data with a continuous all-ones pattern, timed by the master clock strobe.

Every clock in the design is a single-cycle strobe in the `clk` domain: transmit, recovered receive, attenuator and master. Loopback requests come from host register bits or, in hardware mode, from a three-state loop pin. The resolved mode is held in a register, so a change of mode always lands on a clock edge. When a request names more than one loop, the block rejects it. It keeps the last valid mode and raises an error flag. Whether the all-ones pattern or the remote loop wins depends on the control mode.

Top module: `loop_steer`

## Requirements
- R1: While reset is held, and in the cycle after it is released, every output reads zero and the resolved mode is normal.
- R2: In normal mode, `drv_stb`/`drv_data` copy `tx_stb`/`tx_data` and `rcv_stb`/`rcv_data` copy `rec_stb`/`rec_data`. Each output pair is registered with one clock of latency, and a data output holds its value in cycles where its strobe is low.
- R3: In analog loop mode, the receive outputs carry exactly what the driver outputs carry, and `rec_stb`/`rec_data` are ignored.
- R4: In digital loop mode, the line side still gets the transmit strobe and data. The receive side gets `tx_stb` with `enc_data` when `ja_en`=0, or `att_stb` with `att_data` when `ja_en`=1.
- R5: In remote loop mode, the driver outputs carry `rec_stb`/`rec_data`, `tx_stb`/`tx_data` are ignored, and the receive outputs still carry the recovered data.
- R6: When `hw_mode`=1, the mode comes from `loop_pin` alone: 2'b01 (high) selects analog, 2'b00 (low) selects remote, and 2'b10 or 2'b11 (open) selects normal. The host bits, including the digital bit, are ignored.
- R7: When `hw_mode`=0, `host_ana`, `host_dig` and `host_rem` each select their own loop, and all three clear selects normal.
- R8: A host request with two or more loop bits set leaves the mode unchanged and sets `cfg_err` on the next edge. `cfg_err` clears on the first edge that samples a valid request.
- R9: While the all-ones pattern is active, the driver strobe follows `mclk_stb`, driver data is all ones, and `tx_stb`/`tx_data` are ignored. In analog loop mode the receive side sees the all-ones pattern. In digital loop mode the receive side keeps the transmit loop path.
- R10: In host mode `taos_req` takes priority over remote loop on the line side. In hardware mode remote loop takes priority over `taos_req`.
- R11: A control change sampled at edge N sets the mode at edge N. The outputs follow the new mode from edge N+1, and the output registered at edge N still uses the old mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; every strobe is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_mode | input | 1 | 1 = pin-controlled loops, 0 = host bits |
| loop_pin | input | 2 | Three-state loop pin: 00 low, 01 high, 1x open |
| host_ana | input | 1 | Host request for analog loop |
| host_dig | input | 1 | Host request for digital loop |
| host_rem | input | 1 | Host request for remote loop |
| taos_req | input | 1 | Request to send the all-ones pattern to the line |
| ja_en | input | 1 | Digital loop passes through the jitter attenuator |
| mclk_stb | input | 1 | Master clock strobe that times the all-ones pattern |
| tx_stb | input | 1 | Transmit clock strobe |
| tx_data | input | DATA_W | Transmit symbol |
| enc_data | input | DATA_W | Encoder output, timed by tx_stb |
| att_stb | input | 1 | Jitter attenuator output strobe |
| att_data | input | DATA_W | Jitter attenuator output symbol |
| rec_stb | input | 1 | Recovered receive clock strobe |
| rec_data | input | DATA_W | Recovered receive symbol |
| drv_stb | output | 1 | Strobe toward the line driver |
| drv_data | output | DATA_W | Symbol toward the line driver |
| rcv_stb | output | 1 | Strobe toward the receive outputs |
| rcv_data | output | DATA_W | Symbol toward the receive outputs |
| cfg_err | output | 1 | Last sampled loop request was invalid |

## Verification
The assertions assume that every strobe input is a clean single-cycle level in the `clk` domain and that `loop_pin` is always one of its four codes, never X. They also assume the control inputs hold still over each edge they are sampled on. The stimulus changes control and data only at falling edges. It keeps strobes low while a mode settles and then pulses them for one cycle, so every checked edge sees a fully settled mode and a single strobe event.

// File: rtl/loop_steer_pkg.sv
package loop_steer_pkg;

  typedef enum logic [1:0] {
    M_NORM = 2'd0,
    M_ANA  = 2'd1,
    M_DIG  = 2'd2,
    M_REM  = 2'd3
  } path_mode_t;

  localparam logic [1:0] PIN_LOW  = 2'b00;
  localparam logic [1:0] PIN_HIGH = 2'b01;

  typedef struct packed {
    logic ana;
    logic dig;
    logic rem;
  } loop_req_t;

  // Pin control offers no digital loop; an open pin gives no request.
  function automatic loop_req_t decode_req(input logic hw, input logic [1:0] pin,
                                           input logic h_ana, input logic h_dig,
                                           input logic h_rem);
    loop_req_t r;
    if (hw) begin
      r.ana = (pin == PIN_HIGH);
      r.dig = 1'b0;
      r.rem = (pin == PIN_LOW);
    end else begin
      r.ana = h_ana;
      r.dig = h_dig;
      r.rem = h_rem;
    end
    return r;
  endfunction

  function automatic logic req_invalid(input loop_req_t r);
    return (r.ana & r.dig) | (r.ana & r.rem) | (r.dig & r.rem);
  endfunction

  function automatic path_mode_t req_to_mode(input loop_req_t r);
    if (r.ana) return M_ANA;
    if (r.dig) return M_DIG;
    if (r.rem) return M_REM;
    return M_NORM;
  endfunction

  // Host: all-ones beats remote loop. Pins: remote loop beats all-ones.
  function automatic logic ones_active(input logic hw, input logic req,
                                       input path_mode_t m);
    return hw ? (req && (m != M_REM)) : req;
  endfunction

endpackage

// File: rtl/lps_mode_ctrl.sv
module lps_mode_ctrl
  import loop_steer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_mode,
  input  logic [1:0] loop_pin,
  input  logic       host_ana,
  input  logic       host_dig,
  input  logic       host_rem,
  output path_mode_t mode_q,
  output logic       cfg_err_q,
  output logic       req_conflict
);

  loop_req_t  req;
  path_mode_t req_mode;

  assign req          = decode_req(hw_mode, loop_pin, host_ana, host_dig, host_rem);
  assign req_conflict = req_invalid(req);
  assign req_mode     = req_to_mode(req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= M_NORM;
      cfg_err_q <= 1'b0;
    end else begin
      if (!req_conflict) mode_q <= req_mode;
      cfg_err_q <= req_conflict;
    end
  end

  assert_conflict_holds_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_conflict |=> $stable(mode_q));

  assert_conflict_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_conflict |=> cfg_err_q);

  assert_pins_never_digital_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_mode |=> (mode_q != M_DIG));

  assert_pin_high_analog_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mode && loop_pin == PIN_HIGH) |=> (mode_q == M_ANA));

endmodule

// File: rtl/lps_path_mux.sv
module lps_path_mux
  import loop_steer_pkg::*;
#(
  parameter int DATA_W = 2
) (
  input  path_mode_t        mode,
  input  logic              ones_on,
  input  logic              ja_en,
  input  logic              mclk_stb,
  input  logic              tx_stb,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [DATA_W-1:0] enc_data,
  input  logic              att_stb,
  input  logic [DATA_W-1:0] att_data,
  input  logic              rec_stb,
  input  logic [DATA_W-1:0] rec_data,
  output logic              drv_sel_stb,
  output logic [DATA_W-1:0] drv_sel_data,
  output logic              rcv_sel_stb,
  output logic [DATA_W-1:0] rcv_sel_data
);

  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

  always_comb begin
    if (ones_on) begin
      drv_sel_stb  = mclk_stb;
      drv_sel_data = ALL_ONES;
    end else if (mode == M_REM) begin
      drv_sel_stb  = rec_stb;
      drv_sel_data = rec_data;
    end else begin
      drv_sel_stb  = tx_stb;
      drv_sel_data = tx_data;
    end
  end

  always_comb begin
    unique case (mode)
      M_ANA: begin
        rcv_sel_stb  = drv_sel_stb;
        rcv_sel_data = drv_sel_data;
      end
      M_DIG: begin
        rcv_sel_stb  = ja_en ? att_stb  : tx_stb;
        rcv_sel_data = ja_en ? att_data : enc_data;
      end
      default: begin
        rcv_sel_stb  = rec_stb;
        rcv_sel_data = rec_data;
      end
    endcase
  end

endmodule

// File: rtl/lps_out_stage.sv
module lps_out_stage #(
  parameter int DATA_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              stb_q,
  output logic [DATA_W-1:0] data_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q  <= 1'b0;
      data_q <= '0;
    end else begin
      stb_q <= stb_in;
      if (stb_in) data_q <= data_in;
    end
  end

  assert_hold_between_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_in |=> $stable(data_q));

endmodule

// File: rtl/loop_steer.sv
module loop_steer
  import loop_steer_pkg::*;
#(
  parameter int DATA_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_mode,
  input  logic [1:0]        loop_pin,
  input  logic              host_ana,
  input  logic              host_dig,
  input  logic              host_rem,
  input  logic              taos_req,
  input  logic              ja_en,
  input  logic              mclk_stb,
  input  logic              tx_stb,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [DATA_W-1:0] enc_data,
  input  logic              att_stb,
  input  logic [DATA_W-1:0] att_data,
  input  logic              rec_stb,
  input  logic [DATA_W-1:0] rec_data,
  output logic              drv_stb,
  output logic [DATA_W-1:0] drv_data,
  output logic              rcv_stb,
  output logic [DATA_W-1:0] rcv_data,
  output logic              cfg_err
);

  localparam int LANES    = 2;
  localparam int LANE_DRV = 0;
  localparam int LANE_RCV = 1;

  path_mode_t        mode_q;
  logic              req_conflict;
  logic              ones_on;
  logic              sel_stb  [LANES];
  logic [DATA_W-1:0] sel_data [LANES];
  logic              out_stb  [LANES];
  logic [DATA_W-1:0] out_data [LANES];

  lps_mode_ctrl u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_mode      (hw_mode),
    .loop_pin     (loop_pin),
    .host_ana     (host_ana),
    .host_dig     (host_dig),
    .host_rem     (host_rem),
    .mode_q       (mode_q),
    .cfg_err_q    (cfg_err),
    .req_conflict (req_conflict)
  );

  assign ones_on = ones_active(hw_mode, taos_req, mode_q);

  lps_path_mux #(.DATA_W(DATA_W)) u_mux (
    .mode         (mode_q),
    .ones_on      (ones_on),
    .ja_en        (ja_en),
    .mclk_stb     (mclk_stb),
    .tx_stb       (tx_stb),
    .tx_data      (tx_data),
    .enc_data     (enc_data),
    .att_stb      (att_stb),
    .att_data     (att_data),
    .rec_stb      (rec_stb),
    .rec_data     (rec_data),
    .drv_sel_stb  (sel_stb[LANE_DRV]),
    .drv_sel_data (sel_data[LANE_DRV]),
    .rcv_sel_stb  (sel_stb[LANE_RCV]),
    .rcv_sel_data (sel_data[LANE_RCV])
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lps_out_stage #(.DATA_W(DATA_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb_in  (sel_stb[g]),
      .data_in (sel_data[g]),
      .stb_q   (out_stb[g]),
      .data_q  (out_data[g])
    );
  end

  assign drv_stb  = out_stb[LANE_DRV];
  assign drv_data = out_data[LANE_DRV];
  assign rcv_stb  = out_stb[LANE_RCV];
  assign rcv_data = out_data[LANE_RCV];

  assert_host_ones_win_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_mode && taos_req && mclk_stb) |=> (drv_stb && drv_data == {DATA_W{1'b1}}));

  assert_pin_remote_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mode && mode_q == M_REM && rec_stb) |=> (drv_stb && drv_data == $past(rec_data)));

  assert_analog_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ANA) |=> ((rcv_stb == drv_stb) && (!rcv_stb || rcv_data == drv_data)));

  assert_remote_ignores_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_REM && !ones_on && !rec_stb) |=> !drv_stb);

endmodule

// File: tb/loop_steer_tb_top.sv
module loop_steer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_mode = 1'b0;
  logic [1:0] loop_pin = 2'b10;
  logic       host_ana = 1'b0, host_dig = 1'b0, host_rem = 1'b0;
  logic       taos_req = 1'b0, ja_en = 1'b0, mclk_stb = 1'b0;
  logic       tx_stb = 1'b0, att_stb = 1'b0, rec_stb = 1'b0;
  logic [1:0] tx_data = '0, enc_data = '0, att_data = '0, rec_data = '0;
  logic       drv_stb, rcv_stb, cfg_err;
  logic [1:0] drv_data, rcv_data;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  typedef struct {
    int         due;
    logic       ds;
    logic [1:0] dd;
    logic       rs;
    logic [1:0] rd;
    logic       er;
    bit         cd;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;

  loop_steer #(.DATA_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .loop_pin(loop_pin),
    .host_ana(host_ana), .host_dig(host_dig), .host_rem(host_rem),
    .taos_req(taos_req), .ja_en(ja_en), .mclk_stb(mclk_stb),
    .tx_stb(tx_stb), .tx_data(tx_data), .enc_data(enc_data),
    .att_stb(att_stb), .att_data(att_data),
    .rec_stb(rec_stb), .rec_data(rec_data),
    .drv_stb(drv_stb), .drv_data(drv_data),
    .rcv_stb(rcv_stb), .rcv_data(rcv_data), .cfg_err(cfg_err)
  );

  // Monitor: a quarter period after each rising edge, pop due items and compare.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      cyc++;
      while (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (drv_stb !== e.ds || ((e.ds || e.cd) && drv_data !== e.dd) ||
            rcv_stb !== e.rs || ((e.rs || e.cd) && rcv_data !== e.rd) ||
            cfg_err !== e.er) begin
          bad++;
          $display("FAIL %s: actual drv=%b/%b rcv=%b/%b err=%b expected drv=%b/%b rcv=%b/%b err=%b",
                   e.tag, drv_stb, drv_data, rcv_stb, rcv_data, cfg_err,
                   e.ds, e.dd, e.rs, e.rd, e.er);
        end
      end
    end
  end

  task automatic expect_at(input int ahead, input logic ds, input logic [1:0] dd,
                           input logic rs, input logic [1:0] rd, input logic er,
                           input bit cd, input string tag);
    exp_t e;
    e.due = cyc + ahead; e.ds = ds; e.dd = dd; e.rs = rs; e.rd = rd;
    e.er = er; e.cd = cd; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic clear_stb();
    tx_stb = 0; att_stb = 0; rec_stb = 0; mclk_stb = 0;
  endtask

  task automatic set_ctrl(input logic hw, input logic [1:0] pin, input logic a,
                          input logic d, input logic r, input logic t, input logic j);
    @(negedge clk);
    clear_stb();
    hw_mode = hw; loop_pin = pin; host_ana = a; host_dig = d; host_rem = r;
    taos_req = t; ja_en = j;
    repeat (3) @(negedge clk);
  endtask

  // Caller has set strobes and data at a falling edge; expect them one edge later.
  task automatic pulse(input logic ds, input logic [1:0] dd, input logic rs,
                       input logic [1:0] rd, input logic er, input string tag);
    expect_at(1, ds, dd, rs, rd, er, 1'b0, tag);
    @(negedge clk);
    clear_stb();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (drv_stb !== 0 || drv_data !== 0 || rcv_stb !== 0 || rcv_data !== 0 || cfg_err !== 0) begin
      bad++;
      $display("FAIL R1 in reset: actual %b %b %b %b %b expected all zero",
               drv_stb, drv_data, rcv_stb, rcv_data, cfg_err);
    end
    rst_n = 1'b1;
    expect_at(1, 0, 2'b00, 0, 2'b00, 0, 1'b1, "R1 after release");
    @(negedge clk);

    // R2 normal path
    set_ctrl(0, 2'b10, 0, 0, 0, 0, 0);
    tx_stb = 1; tx_data = 2'b10; rec_stb = 1; rec_data = 2'b01;
    pulse(1, 2'b10, 1, 2'b01, 0, "R2 normal both");
    expect_at(1, 0, 2'b10, 0, 2'b01, 0, 1'b1, "R2 hold between strobes");
    @(negedge clk);
    tx_stb = 1; tx_data = 2'b01;
    pulse(1, 2'b01, 0, 2'b00, 0, "R2 normal tx only");

    // R7 / R3 host analog loop
    set_ctrl(0, 2'b10, 1, 0, 0, 0, 0);
    tx_stb = 1; tx_data = 2'b10; rec_stb = 1; rec_data = 2'b01;
    pulse(1, 2'b10, 1, 2'b10, 0, "R3 R7 analog mirror");

    // R9 all ones in analog loop
    set_ctrl(0, 2'b10, 1, 0, 0, 1, 0);
    mclk_stb = 1; tx_stb = 1; tx_data = 2'b00;
    pulse(1, 2'b11, 1, 2'b11, 0, "R9 analog all ones");
    tx_stb = 1; tx_data = 2'b01;
    pulse(0, 2'b00, 0, 2'b00, 0, "R9 tx strobe ignored");

    // R4 digital loop, attenuator bypassed then used
    set_ctrl(0, 2'b10, 0, 1, 0, 0, 0);
    tx_stb = 1; tx_data = 2'b01; enc_data = 2'b10; att_stb = 1; att_data = 2'b11;
    rec_stb = 1; rec_data = 2'b00;
    pulse(1, 2'b01, 1, 2'b10, 0, "R4 digital encoder tap");
    set_ctrl(0, 2'b10, 0, 1, 0, 0, 1);
    att_stb = 1; att_data = 2'b11;
    pulse(0, 2'b00, 1, 2'b11, 0, "R4 digital via attenuator");

    // R9 all ones in digital loop
    set_ctrl(0, 2'b10, 0, 1, 0, 1, 0);
    mclk_stb = 1; tx_stb = 1; tx_data = 2'b00; enc_data = 2'b01;
    pulse(1, 2'b11, 1, 2'b01, 0, "R9 digital keeps loop");

    // R5 host remote loop
    set_ctrl(0, 2'b10, 0, 0, 1, 0, 0);
    tx_stb = 1; tx_data = 2'b00; rec_stb = 1; rec_data = 2'b10;
    pulse(1, 2'b10, 1, 2'b10, 0, "R5 remote");

    // R10 host: all ones beats remote
    set_ctrl(0, 2'b10, 0, 0, 1, 1, 0);
    mclk_stb = 1; rec_stb = 1; rec_data = 2'b01; tx_stb = 1; tx_data = 2'b10;
    pulse(1, 2'b11, 1, 2'b01, 0, "R10 host ones over remote");

    // R6 pin high -> analog; host remote bit ignored
    set_ctrl(1, 2'b01, 0, 0, 1, 0, 0);
    tx_stb = 1; tx_data = 2'b10; rec_stb = 1; rec_data = 2'b01;
    pulse(1, 2'b10, 1, 2'b10, 0, "R6 pin high analog");

    // R6 pin low -> remote; R10 remote beats all ones
    set_ctrl(1, 2'b00, 0, 0, 0, 1, 0);
    mclk_stb = 1; tx_stb = 1; tx_data = 2'b01; rec_stb = 1; rec_data = 2'b10;
    pulse(1, 2'b10, 1, 2'b10, 0, "R6 R10 pin remote over ones");

    // R6 pin open -> normal; host digital bit ignored
    set_ctrl(1, 2'b10, 0, 1, 0, 0, 0);
    tx_stb = 1; tx_data = 2'b01; rec_stb = 1; rec_data = 2'b10;
    pulse(1, 2'b01, 1, 2'b10, 0, "R6 pin open normal");

    // R8 conflict keeps analog, flags error, then clears
    set_ctrl(0, 2'b10, 1, 0, 0, 0, 0);
    set_ctrl(0, 2'b10, 1, 0, 1, 0, 0);
    tx_stb = 1; tx_data = 2'b01; rec_stb = 1; rec_data = 2'b10;
    pulse(1, 2'b01, 1, 2'b01, 1, "R8 conflict keeps analog");
    set_ctrl(0, 2'b10, 0, 0, 0, 0, 0);
    tx_stb = 1; tx_data = 2'b10; rec_stb = 1; rec_data = 2'b11;
    pulse(1, 2'b10, 1, 2'b11, 0, "R8 error clears");

    // R11 mode change lands one edge after its sampling edge
    host_rem = 1; tx_stb = 1; tx_data = 2'b01; rec_stb = 1; rec_data = 2'b10;
    expect_at(1, 1, 2'b01, 1, 2'b10, 0, 1'b0, "R11 old mode at edge N");
    expect_at(2, 1, 2'b10, 1, 2'b10, 0, 1'b0, "R11 new mode at edge N+1");
    repeat (2) @(negedge clk);
    clear_stb();

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule